// File: doc/BRIEF.md
# Pattern-Locked Transparent Serial Receiver

This block takes an unframed serial bit stream, one bit per cycle in which `bit_en` is high, and turns it into bytes. It has two ways to gain synchronization. In pattern mode it watches a sliding window of the last 16 received bits and does not deliver any data until that window equals a programmable sync word. In inherent mode it counts as synchronized as soon as it is enabled with carrier present, and it keeps every bit it receives, including a bit that arrives in the same cycle that carrier-detect rises.

The stream has no closing flag. The only way to end a frame is to drop carrier-detect. When that happens the block pulses an end-of-frame strobe, discards any partly built byte and loses sync. In pattern mode it then hunts for the sync word again from an empty window. A transmit-start output can be held back until eight bit clocks after lock, so that a companion transmitter starts in step with the receiver. Without that hold it simply follows the enable.

Output bytes leave through a valid/ready pair. A completed byte is held, with `out_data` stable, until `out_ready` is seen high. The serial line cannot be stalled, so back-pressure cannot slow the input. If a new byte completes while the previous one is still waiting, the new byte replaces it.

Top module: `tsync_rx`

## Requirements
- R1: After reset, `out_valid`, `synced`, `eof_pulse` and `tx_start` are all low.
- R2: With `mode_pattern`=1, no byte is delivered and `synced` stays low until the last 16 accepted bits equal `sync_pattern`. Bit 15 of the pattern is the earliest of those bits and bit 0 the latest. `synced` goes high on the clock edge that accepts the matching bit.
- R3: Byte assembly starts with the bit that immediately follows the last pattern bit. With `bit_rev`=0 the first bit of a byte lands in bit 0 of `out_data` (LSB-first). With `bit_rev`=1 it lands in bit 7.
- R4: With `mode_pattern`=0, `synced` goes high on the first edge at which `enable` and `cd` are both high. Every bit taken while both are high is delivered, including a bit taken in the same cycle that `cd` rises.
- R5: With `tx_sync_en`=1, `tx_start` rises on the edge of the eighth `bit_en` cycle taken while `synced` is already high. It stays high until sync is lost or the block is disabled.
- R6: With `tx_sync_en`=0, `tx_start` is high from the first edge after `enable` is seen high.
- R7: If `cd` falls while synced, `eof_pulse` is high for exactly one cycle after the edge that sees `cd` low, and `synced` clears on that same edge. A partly assembled byte is discarded. In pattern mode, a full 16 new bits must match before sync returns.
- R8: When `enable` is low at an edge, `synced` and `tx_start` are low after that edge.
- R9: `out_valid` rises on the edge that takes the last bit of a byte. It stays high with `out_data` unchanged until an edge at which `out_ready` is high. A byte that completes while an older byte is still waiting overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| enable | input | 1 | Receiver enable |
| mode_pattern | input | 1 | 1: hunt for sync word, 0: inherent sync |
| bit_rev | input | 1 | 1: first bit of a byte goes to MSB |
| tx_sync_en | input | 1 | 1: hold tx_start until eight bit clocks after lock |
| sync_pattern | input | 16 | Sync word, bit 15 earliest on the line |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| bit_in | input | 1 | Serial data bit |
| cd | input | 1 | Carrier detect, active high |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| synced | output | 1 | Receiver synchronized |
| eof_pulse | output | 1 | One-cycle end-of-frame strobe |
| tx_start | output | 1 | Transmit-start enable |

## Verification
Any corruption in the hunt window or its fill count shows up first at `synced`. A false lock or a missed lock moves the rise by at least one bit clock, and every later byte is then shifted. A slipped bit counter in the byte packer makes the very next `out_valid` arrive at the wrong bit, and the first byte after lock comes out rotated. An error in the transmit-delay counter moves `tx_start` away from the edge of the first completed byte after a pattern lock. Because every bit is compared against an arithmetic model, each of these faults appears within one byte time of its cause.

// File: rtl/tsrx_pkg.sv
package tsrx_pkg;
  localparam int PAT_W_DEF    = 16;
  localparam int BYTE_W_DEF   = 8;
  localparam int TX_DELAY_DEF = 8;
endpackage

// File: rtl/tsrx_hunt.sv
module tsrx_hunt #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [PAT_W-1:0] pattern,
  output logic             match
);
  localparam int FW = $clog2(PAT_W);
  localparam logic [FW-1:0] FULL = FW'(PAT_W - 1);

  logic [PAT_W-2:0] win;
  logic [FW-1:0]    fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
    end else if (clear) begin
      fill <= '0;
    end else if (shift_en) begin
      win <= {win[PAT_W-3:0], bit_in};
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  assign match = shift_en && (fill == FULL) && ({win, bit_in} == pattern);

  // R7
  hunt_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !match);
endmodule

// File: rtl/tsrx_pack.sv
module tsrx_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              bit_in,
  input  logic              bit_rev,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LASTI = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt, idx;
  logic [BYTE_W-1:0] acc, nxt;
  logic              take_ok, byte_done;

  assign take_ok   = take && !clear;
  assign idx       = bit_rev ? (LASTI - cnt) : cnt;
  assign byte_done = take_ok && (cnt == LASTI);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                          acc[i] <= 1'b0;
      else if (take_ok && idx == CW'(i))   acc[i] <= bit_in;
    end
    assign nxt[i] = (idx == CW'(i)) ? bit_in : acc[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (take)      cnt <= (cnt == LASTI) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (byte_done) begin
      out_data  <= nxt;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !byte_done) |=> (out_valid && $stable(out_data)));
  // R7
  drop_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !$rose(out_valid));
endmodule

// File: rtl/tsrx_txgate.sv
module tsrx_txgate #(
  parameter int TX_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_sync_en,
  input  logic locked,
  input  logic bit_en,
  output logic tx_start
);
  localparam int CW = $clog2(TX_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(TX_DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tx_start <= 1'b0;
    end else if (!enable) begin
      cnt      <= '0;
      tx_start <= 1'b0;
    end else if (!tx_sync_en) begin
      cnt      <= '0;
      tx_start <= 1'b1;
    end else if (!locked) begin
      cnt      <= '0;
      tx_start <= 1'b0;
    end else if (bit_en && !tx_start) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) tx_start <= 1'b1;
    end
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_start) |-> $past(!enable || !locked));
  // R5
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_start) && $past(tx_sync_en)) |-> $past(bit_en && locked));
endmodule

// File: rtl/tsync_rx.sv
module tsync_rx
  import tsrx_pkg::*;
#(
  parameter int PAT_W    = PAT_W_DEF,
  parameter int BYTE_W   = BYTE_W_DEF,
  parameter int TX_DELAY = TX_DELAY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_pattern,
  input  logic              bit_rev,
  input  logic              tx_sync_en,
  input  logic [PAT_W-1:0]  sync_pattern,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              cd,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              synced,
  output logic              eof_pulse,
  output logic              tx_start
);
  logic live, clear, locked, hunt_shift, hunt_match, take;

  assign live       = enable && cd;
  assign clear      = !live;
  assign hunt_shift = bit_en && live && mode_pattern && !locked;
  assign take       = bit_en && live && (!mode_pattern || locked);

  tsrx_hunt #(.PAT_W(PAT_W)) u_hunt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .shift_en(hunt_shift),
    .bit_in(bit_in), .pattern(sync_pattern), .match(hunt_match)
  );

  tsrx_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .bit_in(bit_in),
    .bit_rev(bit_rev), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid)
  );

  tsrx_txgate #(.TX_DELAY(TX_DELAY)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_sync_en(tx_sync_en),
    .locked(locked), .bit_en(bit_en), .tx_start(tx_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      eof_pulse <= 1'b0;
    end else begin
      eof_pulse <= enable && !cd && locked;
      if (!live)              locked <= 1'b0;
      else if (!mode_pattern) locked <= 1'b1;
      else if (hunt_match)    locked <= 1'b1;
    end
  end

  assign synced = locked;

  // R8
  synced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !synced);
  // R8
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_start);
  // R7
  eof_unsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> !synced);
  // R2
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(!mode_pattern || hunt_match));
endmodule

// File: tb/tsync_rx_test.sv
module tsync_rx_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic enable = 0, mode_pattern = 0, bit_rev = 0, tx_sync_en = 0;
  logic [15:0] sync_pattern = '0;
  logic bit_en = 0, bit_in = 0, cd = 0, out_ready = 1;
  logic [7:0] out_data;
  logic out_valid, synced, eof_pulse, tx_start;

  int total = 0, bad = 0, cycles = 0;

  logic       m_locked, m_valid, raise_cd;
  logic [15:0] m_win;
  logic [7:0] m_acc, m_data;
  int m_fill, m_cnt, m_txc;

  always #(CLK_NS/2) clk = ~clk;

  tsync_rx uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_pattern(mode_pattern),
    .bit_rev(bit_rev), .tx_sync_en(tx_sync_en), .sync_pattern(sync_pattern),
    .bit_en(bit_en), .bit_in(bit_in), .cd(cd), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .synced(synced),
    .eof_pulse(eof_pulse), .tx_start(tx_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tx();
    return tx_sync_en ? (m_txc >= 8) : 1'b1;
  endfunction

  task automatic model_clear(input logic lock_now);
    m_locked = lock_now; m_fill = 0; m_cnt = 0; m_txc = 0; m_win = '0;
  endtask

  task automatic send_bit(input logic b);
    logic old, done, hit;
    int idx;
    @(negedge clk);
    bit_in = b; bit_en = 1;
    if (raise_cd) begin cd = 1; raise_cd = 0; end
    old = m_locked; done = 0;
    if (!mode_pattern || old) begin
      idx = bit_rev ? 7 - m_cnt : m_cnt;
      m_acc[idx] = b;
      m_cnt++;
      if (m_cnt == 8) begin m_cnt = 0; done = 1; m_data = m_acc; end
      if (old && m_txc < 8) m_txc++;
    end
    if (mode_pattern && !old) begin
      hit = (m_fill >= 15) && ({m_win[14:0], b} == sync_pattern);
      m_win = {m_win[14:0], b};
      if (m_fill < 15) m_fill++;
      if (hit) m_locked = 1;
    end
    if (!mode_pattern) m_locked = 1;
    m_valid = done || (m_valid && !out_ready);
    @(negedge clk);
    bit_en = 0;
    chk(mode_pattern ? "R2 synced" : "R4 synced", synced, m_locked);
    chk("R9 out_valid", out_valid, m_valid);
    if (m_valid) chk(bit_rev ? "R3 data msb-first" : "R3 data lsb-first", out_data, m_data);
    chk(tx_sync_en ? "R5 tx_start" : "R6 tx_start", tx_start, exp_tx());
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic restart(input logic pm, input logic rv, input logic ts, input logic [15:0] pat);
    @(negedge clk);
    enable = 0; cd = 0;
    @(negedge clk);
    chk("R8 synced off", synced, 0);
    chk("R8 tx off", tx_start, 0);
    mode_pattern = pm; bit_rev = rv; tx_sync_en = ts; sync_pattern = pat;
    out_ready = 1;
    @(negedge clk);
    enable = 1; cd = 1;
    @(negedge clk);
    model_clear(!pm);
    m_valid = 0;
    chk(pm ? "R2 no early sync" : "R4 sync on enable", synced, !pm);
    chk(ts ? "R5 tx held" : "R6 tx on enable", tx_start, !ts);
  endtask

  task automatic drop_cd();
    logic e;
    @(negedge clk);
    cd = 0; e = m_locked;
    @(negedge clk);
    chk("R7 eof pulse", eof_pulse, e);
    chk("R7 sync cleared", synced, 0);
    @(negedge clk);
    chk("R7 eof one cycle", eof_pulse, 0);
    model_clear(!mode_pattern);
    chk("R7 tx after loss", tx_start, !tx_sync_en);
    cd = 1;
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_valid = 0; raise_cd = 0; m_acc = '0; m_data = '0;
    model_clear(0);
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 synced", synced, 0);
    chk("R1 eof", eof_pulse, 0);
    chk("R1 tx_start", tx_start, 0);
    rst_n = 1;

    // pattern mode sweep: patterns, bit order, transmit hold
    for (int s = 0; s < 16; s++) begin
      logic [15:0] pat;
      pat = 16'hA5C3 ^ 16'(s * 16'h1357);
      restart(1, s[0], !s[1], pat);
      for (int k = 0; k < 20; k++) send_bit(1'((k * 37 + s * 11) >> 2));
      for (int i = 15; i >= 0; i--) send_bit(pat[i]);
      chk("R2 locked after pattern", synced, 1);
      for (int j = 0; j < 3; j++) send_byte(8'((s * 29 + j * 71) & 255));
      for (int i = 0; i < 4; i++) send_bit(1'(i + s));
      drop_cd();
      for (int k = 0; k < 10; k++) send_bit(pat[k]);
      chk("R7 rehunt", synced, 0);
    end

    // inherent mode: first bit on cd rise, back-pressure
    for (int s = 0; s < 4; s++) begin
      restart(0, s[0], s[1], 16'h0);
      @(negedge clk); cd = 0;
      @(negedge clk);
      model_clear(0);
      raise_cd = 1;
      send_byte(8'h5A ^ 8'(s));
      send_byte(8'hC3 + 8'(s));
      out_ready = 0;
      send_byte(8'h96);
      repeat (3) begin
        @(negedge clk);
        chk("R9 held valid", out_valid, 1);
        chk("R9 held data", out_data, m_data);
      end
      send_byte(8'h3C ^ 8'(s));
      out_ready = 1;
      @(negedge clk);
      @(negedge clk);
      m_valid = 0;
      chk("R9 accepted", out_valid, 0);
      send_bit(1); send_bit(0);
      drop_cd();
      send_byte(8'hE1);
    end

    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R8 disable synced", synced, 0);
    chk("R8 disable tx", tx_start, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule